// File: doc/BRIEF.md
# Two-Level Page Table Walker

The block converts a 32-bit linear address into a 32-bit physical address. It walks a two-level tree in memory: a directory, located by a base register, then a page table. A request carries the linear address, a write flag and a user-mode flag. The block reads the entries it needs through a single 32-bit memory port. It returns either the physical address or a fault with a cause code.

Directory entries may map a 4 MB region directly, in which case the walk stops after one read. The walker keeps the accessed and dirty status bits of the entries up to date by writing the entries back. It writes an entry only when one of those bits actually changes, and only when the walk ends without a fault. Permission bits of the two levels combine by AND, so either level can revoke write or user access.

The walker serves one request at a time. The memory port holds each read or write steady until the memory acknowledges it.

Top module: `pt_walker`

## Requirements
- R1: The first access of every walk is a read at {dir_base[31:12], lin[31:22], 2'b00}. The low 12 bits of the base are ignored.
- R2: When the directory entry has bit 7 clear, the second read is at {dir_entry[31:12], lin[21:12], 2'b00}. A successful result is {table_entry[31:12], lin[11:0]}.
- R3: When the directory entry has bit 7 set, no table read occurs. A successful result is {dir_entry[31:22], lin[21:0]}.
- R4: An entry that is used and has bit 0 (present) clear ends the walk with a fault of cause 1.
- R5: A user-mode access faults with cause 3 when bit 2 (user) is clear in either level, or in the large directory entry. This check ranks above the write check.
- R6: A write faults with cause 2 when bit 1 (writable) is clear in either level, or in the large directory entry.
- R7: On success, an entry whose bit 5 (accessed) is clear is written back with bit 5 set. The directory entry is written before the table entry.
- R8: On a successful write, the final entry gets bit 6 (dirty) set. That is the table entry, or the large directory entry. A directory entry that points to a table never gets bit 6 from the walker.
- R9: No write-back occurs when the status bits are already set, and none occurs on a faulting walk.
- R10: A write-back changes only bits 5 and 6. The available bits 11:9 and all other bits keep their read values.
- R11: A request is taken while req_ready is high. Each walk gives exactly one single-cycle rsp_valid pulse. The memory read and write strobes are never high together, and each strobe holds its address until mem_ack. Cause 0 means no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| dir_base | input | 32 | Directory base address, sampled when a request is taken |
| rsp_valid | output | 1 | Result valid, one cycle |
| rsp_phys | output | 32 | Physical address (zero on a fault) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_cause | output | 2 | 0 ok, 1 not present, 2 write denied, 3 user denied |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_rdata | input | 32 | Entry value read, valid with mem_ack |
| mem_ack | input | 1 | Memory access complete |

## Verification
The hardest situation to reach is a walk that would need status updates but faults at the table level. In that case a directory entry with its accessed bit clear must stay untouched. The bench builds a directory entry with bit 5 clear that points to an empty table slot. It checks both the zero write count and the unchanged entry in the memory model. Permission ordering is reached with an entry pair where a user write fails both tests. Dirty handling is reached by repeating the same address, first as a read and then as a write. This exercises the case where only bit 6 changes.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_lin,
  input  logic        req_write,
  input  logic        req_user,
  input  logic [31:0] dir_base,
  output logic        rsp_valid,
  output logic [31:0] rsp_phys,
  output logic        rsp_fault,
  output logic [1:0]  rsp_cause,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack
);
  localparam int P_B = 0, RW_B = 1, US_B = 2, A_B = 5, D_B = 6, PS_B = 7;

  typedef enum logic [2:0] {S_IDLE, S_RD_DIR, S_RD_TBL, S_WB_DIR, S_WB_TBL, S_RESP} st_t;
  st_t st;

  logic [31:0] lin, pde, pte;
  logic [19:0] base_hi;
  logic        wr, usr, big;
  logic [1:0]  cause;

  function automatic logic [1:0] perm(input logic [31:0] e, input logic w, input logic u);
    if (!e[P_B])            return 2'd1;
    else if (u && !e[US_B]) return 2'd3;
    else if (w && !e[RW_B]) return 2'd2;
    else                    return 2'd0;
  endfunction

  wire [31:0] pde_addr = {base_hi, lin[31:22], 2'b00};
  wire [31:0] pte_addr = {pde[31:12], lin[21:12], 2'b00};
  wire [31:0] pde_new  = pde | (32'd1 << A_B) | ((big && wr) ? (32'd1 << D_B) : 32'd0);
  wire [31:0] pte_new  = pte | (32'd1 << A_B) | (wr ? (32'd1 << D_B) : 32'd0);
  wire        pte_upd  = pte_new != pte;

  wire [31:0] eff_pte  = {mem_rdata[31:3], mem_rdata[US_B] & pde[US_B],
                          mem_rdata[RW_B] & pde[RW_B], mem_rdata[P_B]};
  wire [1:0]  dir_c    = perm(mem_rdata, wr, usr);
  wire [1:0]  tbl_c    = perm(eff_pte, wr, usr);
  wire        rd_upd   = !mem_rdata[A_B] || (wr && !mem_rdata[D_B]);

  assign req_ready = st == S_IDLE;
  assign mem_rd    = st == S_RD_DIR || st == S_RD_TBL;
  assign mem_wr    = st == S_WB_DIR || st == S_WB_TBL;
  assign mem_addr  = (st == S_RD_DIR || st == S_WB_DIR) ? pde_addr : pte_addr;
  assign mem_wdata = (st == S_WB_DIR) ? pde_new : pte_new;
  assign rsp_valid = st == S_RESP;
  assign rsp_fault = cause != 2'd0;
  assign rsp_cause = cause;
  assign rsp_phys  = rsp_fault ? 32'd0 :
                     big ? {pde[31:22], lin[21:0]} : {pte[31:12], lin[11:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      lin <= '0; pde <= '0; pte <= '0; base_hi <= '0;
      wr <= 1'b0; usr <= 1'b0; big <= 1'b0; cause <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          lin <= req_lin; wr <= req_write; usr <= req_user;
          base_hi <= dir_base[31:12]; cause <= 2'd0; big <= 1'b0;
          st <= S_RD_DIR;
        end
        S_RD_DIR: if (mem_ack) begin
          pde <= mem_rdata;
          if (!mem_rdata[P_B]) begin
            cause <= 2'd1; st <= S_RESP;
          end else if (mem_rdata[PS_B]) begin
            big <= 1'b1; cause <= dir_c;
            st <= (dir_c == 2'd0 && rd_upd) ? S_WB_DIR : S_RESP;
          end else begin
            st <= S_RD_TBL;
          end
        end
        S_RD_TBL: if (mem_ack) begin
          pte <= mem_rdata;
          cause <= tbl_c;
          if (tbl_c != 2'd0)   st <= S_RESP;
          else if (!pde[A_B])  st <= S_WB_DIR;
          else if (rd_upd)     st <= S_WB_TBL;
          else                 st <= S_RESP;
        end
        S_WB_DIR: if (mem_ack) st <= (!big && pte_upd) ? S_WB_TBL : S_RESP;
        S_WB_TBL: if (mem_ack) st <= S_RESP;
        default:  st <= S_IDLE;
      endcase
    end
  end

  logic wrote;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wrote <= 1'b0;
    else if (st == S_IDLE) wrote <= 1'b0;
    else if (mem_wr && mem_ack) wrote <= 1'b1;

  p_no_wb_on_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> !wrote);
  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  p_strobe_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) && !mem_ack |=> (mem_rd || mem_wr) && $stable(mem_addr));
  p_one_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_wb_sets_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_wdata[A_B] && mem_wdata[P_B]);
endmodule

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_user = 0, mem_ack = 0;
  logic [31:0] req_lin = 0, dir_base = 32'h0001_00AB, mem_rdata = 0;
  logic req_ready, rsp_valid, rsp_fault, mem_rd, mem_wr;
  logic [31:0] rsp_phys, mem_addr, mem_wdata;
  logic [1:0] rsp_cause;

  pt_walker u_pt_walker (.*);

  bit [31:0] mem [bit [31:0]];
  int nrd = 0, nwr = 0, errors = 0, checks = 0, nresp = 0;
  logic [31:0] first_addr = 0;
  typedef struct { logic [31:0] phys; logic [1:0] cause; string tag; } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 0;
    else if (mem_rd || mem_wr) begin
      if (nrd + nwr == 0) first_addr = mem_addr;
      mem_ack = 1;
      if (mem_rd) begin mem_rdata = mem[mem_addr]; nrd++; end
      else begin mem[mem_addr] = mem_wdata; nwr++; end
    end
  end

  initial forever begin
    @(negedge clk);
    if (rsp_valid) begin
      exp_t e;
      nresp++;
      if (q.size() == 0) check(0, "R11 unexpected response", rsp_phys, 0);
      else begin
        e = q.pop_front();
        check(rsp_cause == e.cause && rsp_fault == (e.cause != 0), {e.tag, " cause"}, rsp_cause, e.cause);
        check(rsp_phys == e.phys, {e.tag, " phys"}, rsp_phys, e.phys);
      end
    end
  end

  task automatic walk(input logic [31:0] lin, input bit w, input bit u,
                      input logic [31:0] phys, input logic [1:0] cause,
                      input int erd, input int ewr, input string tag);
    int n0;
    exp_t e;
    e.phys = phys; e.cause = cause; e.tag = tag;
    q.push_back(e);
    nrd = 0; nwr = 0; n0 = nresp;
    @(negedge clk);
    req_valid = 1; req_lin = lin; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0;
    while (nresp == n0) @(negedge clk);
    check(nrd == erd, {tag, " read count"}, nrd, erd);
    check(nwr == ewr, {tag, " write count"}, nwr, ewr);
  endtask

  initial begin
    mem[32'h10004] = 32'h0002_0007; mem[32'h2000C] = 32'h1234_5007;
    mem[32'h100C8] = 32'h0FC0_0E87;
    mem[32'h1000C] = 32'h0003_0007;
    mem[32'h10010] = 32'h0004_0003; mem[32'h40000] = 32'h0005_5007;
    mem[32'h40004] = 32'h0006_6005;
    mem[32'h10014] = 32'h0140_0085;
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_valid && !mem_rd && !mem_wr, "R11 reset state",
          {req_ready, rsp_valid, mem_rd, mem_wr}, 4'b1000);
    rst_n = 1;

    walk(32'h0040_3123, 0, 1, 32'h1234_5123, 0, 2, 2, "R2 4KB user read");
    check(first_addr == 32'h10004, "R1 directory address", first_addr, 32'h10004);
    check(mem[32'h10004] == 32'h0002_0027, "R7 dir accessed", mem[32'h10004], 32'h0002_0027);
    check(mem[32'h2000C] == 32'h1234_5027, "R7 tbl accessed", mem[32'h2000C], 32'h1234_5027);
    walk(32'h0040_3123, 0, 0, 32'h1234_5123, 0, 2, 0, "R9 repeat no writeback");
    walk(32'h0040_3FFF, 1, 0, 32'h1234_5FFF, 0, 2, 1, "R8 4KB write");
    check(mem[32'h2000C] == 32'h1234_5067, "R8 tbl dirty", mem[32'h2000C], 32'h1234_5067);
    check(mem[32'h10004] == 32'h0002_0027, "R8 dir not dirty", mem[32'h10004], 32'h0002_0027);

    walk(32'h0C8A_BCDE, 1, 1, 32'h0FCA_BCDE, 0, 1, 1, "R3 4MB write");
    check(mem[32'h100C8] == 32'h0FC0_0EE7, "R10 4MB dirty keeps avl", mem[32'h100C8], 32'h0FC0_0EE7);

    walk(32'h0080_0000, 0, 0, 0, 1, 1, 0, "R4 dir not present");
    walk(32'h00C0_5000, 0, 0, 0, 1, 2, 0, "R4 tbl not present");
    check(mem[32'h1000C] == 32'h0003_0007, "R9 no writeback on fault", mem[32'h1000C], 32'h0003_0007);

    walk(32'h0100_0000, 0, 1, 0, 3, 2, 0, "R5 dir user denied");
    walk(32'h0100_0000, 0, 0, 32'h0005_5000, 0, 2, 2, "R5 supervisor ok");
    walk(32'h0100_1010, 1, 0, 0, 2, 2, 0, "R6 tbl write denied");
    walk(32'h0100_1010, 0, 0, 32'h0006_6010, 0, 2, 1, "R7 tbl only accessed");
    walk(32'h0100_1000, 1, 1, 0, 3, 2, 0, "R5 user before write");

    walk(32'h0141_2345, 1, 1, 0, 2, 1, 0, "R6 4MB write denied");
    walk(32'h0141_2345, 0, 1, 32'h0141_2345, 0, 1, 1, "R3 4MB read");
    check(mem[32'h10014] == 32'h0140_00A5, "R7 4MB accessed only", mem[32'h10014], 32'h0140_00A5);
    check(q.size() == 0, "R11 all responses seen", q.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule